// File: doc/BRIEF.md
# Chained DMA Transfer Sequencer

This block is the transfer engine of a single DMA channel. A start pulse latches the programmed mode fields and the initial device address, memory address, count, descriptor base and block count. In chain mode it first reads a three-word descriptor (memory address high half, low half, count) from memory. It then moves operands one at a time: each operand is read from its source and then written to its destination over a single-beat, 16-bit, big-endian word port with byte enables and a request/acknowledge handshake. After every operand both addresses step as programmed and the count drops by one. When the count runs out, the engine either fetches the next descriptor or finishes with a one-cycle done pulse.

Pacing is automatic, level-gated by DRQ, or one operand per DRQ rising edge. In burst mode a CPU-hold line covers the whole run. An abort pulse stops the engine at once. Register decoding and arbitration between channels belong to the surrounding logic.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the engine is idle: busy, memory request, CPU hold and done are all low.
- R2: When the direction input is 1, the engine reads at the device address and writes at the memory address. When it is 0, it reads at the memory address and writes at the device address.
- R3: Size code 00 or 11 moves one byte, 01 one 16-bit word, and 10 a 32-bit long. A long moves as two word beats, high word at the lower address first. A byte at an even address uses lane [15:8] (enables 10). A byte at an odd address uses lane [7:0] (enables 01). A written byte appears on both lanes.
- R4: Each of the device and memory step fields works the same way: 01 adds the operand size in bytes (1, 2 or 4) after each operand, 10 subtracts it, and 00 or 11 leaves the address unchanged.
- R5: Each operand lowers the count by one, and the block ends when the count reaches zero. A starting count of zero moves exactly one operand.
- R6: If the chain field is nonzero, the start sequence reads words at base, base+2 and base+4 as memory address high, memory address low and count. The block count is then lowered by one if it is nonzero.
- R7: At the end of a block in chain mode with a nonzero block count, the block count drops by one, the base moves up by 6, and the next descriptor is read before transfers resume. The device address carries on from where it was. Otherwise the run completes.
- R8: With class code 00 (burst), CPU hold is high in every cycle the engine is busy and drops at completion. With any other class it stays low.
- R9: Pacing code 11 moves exactly one operand per DRQ rising edge seen while busy.
- R10: Pacing code 10 starts an operand only while DRQ is high. DRQ low holds the engine between operands. Codes 00 and 01 run without waiting.
- R11: An abort pulse returns the engine to idle in the next cycle, with request and CPU hold low and no done pulse. A later start works normally.
- R12: A memory request keeps its address, direction and byte enables unchanged until it is acknowledged.
- R13: Done is a single-cycle pulse in the cycle after the final write beat is acknowledged. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| abort_i | input | 1 | Abort pulse |
| drq_i | input | 1 | Device transfer request |
| cfg_dev_to_mem_i | input | 1 | 1: device to memory, 0: memory to device |
| cfg_size_i | input | 2 | Operand size code |
| cfg_dev_step_i | input | 2 | Device address step code |
| cfg_mem_step_i | input | 2 | Memory address step code |
| cfg_chain_i | input | 2 | Nonzero selects descriptor chaining |
| cfg_pace_i | input | 2 | Pacing code (0x auto, 10 level, 11 edge) |
| cfg_xfer_class_i | input | 2 | 00 selects burst with CPU hold |
| init_dev_addr_i | input | 32 | Starting device byte address |
| init_mem_addr_i | input | 32 | Starting memory byte address (no chain) |
| init_count_i | input | CNT_W | Operand count (no chain) |
| init_base_i | input | 32 | Descriptor array base byte address |
| init_blocks_i | input | BLK_W | Block count for chaining |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 for write beat |
| mem_addr_o | output | 32 | Byte address of the beat |
| mem_be_o | output | 2 | Byte enables, bit 1 = lane [15:8] |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Beat acknowledge |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Engine not idle |
| cpu_hold_o | output | 1 | CPU hold in burst mode |
| done_o | output | 1 | Completion pulse |

## Verification
The bench sweeps every combination of direction, size code and both step codes. The expected memory image comes from a byte-level copy model. A design that swaps the lanes for odd-addressed bytes, writes the low word of a long first, or steps by a fixed amount instead of the operand size ends with a memory image that does not match the model. Chaining is checked by logging the order of the descriptor reads and counting write beats. An off-by-one in the block-count decrement at start uses one descriptor too many or too few. DRQ pacing is probed by watching for beats in quiet windows: a level-mode engine that ignores DRQ, or an edge-mode engine that counts levels, moves extra operands. Abort and busy-time start checks catch an engine that still pulses done or restarts with new settings.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int ADDR_W = 32;
  localparam int WORD_W = 16;
  localparam int DESC_BYTES = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC,
    S_WAIT,
    S_RD,
    S_WR
  } seq_state_e;

  function automatic logic f_is_long(input logic [1:0] sz);
    return sz == 2'b10;
  endfunction

  function automatic logic f_is_byte(input logic [1:0] sz);
    return (sz == 2'b00) || (sz == 2'b11);
  endfunction

  function automatic logic [2:0] f_size_bytes(input logic [1:0] sz);
    case (sz)
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] f_next_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [1:0] ctrl,
                                                   input logic [1:0] sz);
    logic [ADDR_W-1:0] delta;
    delta = ADDR_W'(f_size_bytes(sz));
    case (ctrl)
      2'b01:   return a + delta;
      2'b10:   return a - delta;
      default: return a;
    endcase
  endfunction

  function automatic logic [1:0] f_byte_en(input logic [1:0] sz, input logic a0);
    if (f_is_byte(sz)) return a0 ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

endpackage

// File: rtl/dma_seq_addr_reg.sv
module dma_seq_addr_reg
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic [1:0]        ctrl_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] addr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (step_i) addr_o <= f_next_addr(addr_o, ctrl_i, size_i);
  end

  a_r4_hold_code_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (ctrl_i == 2'b00 || ctrl_i == 2'b11)) |=> $stable(addr_o));

  a_r4_inc_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ctrl_i == 2'b01) |=> (addr_o != $past(addr_o)));

endmodule

// File: rtl/dma_seq_pace.sv
module dma_seq_pace (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic [1:0] mode_i,
  input  logic       drq_i,
  input  logic       consume_i,
  output logic       go_o
);

  logic drq_q;
  logic edge_pend;
  logic drq_rise;
  logic edge_mode;
  logic level_mode;

  assign drq_rise   = drq_i & ~drq_q;
  assign edge_mode  = (mode_i == 2'b11);
  assign level_mode = (mode_i == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q     <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      drq_q <= drq_i;
      if (!active_i) edge_pend <= 1'b0;
      else           edge_pend <= (edge_pend & ~consume_i) | (drq_rise & edge_mode);
    end
  end

  assign go_o = ~mode_i[1] | (level_mode & drq_i) | (edge_mode & edge_pend);

  a_r9_edge_arms_go: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && edge_mode && drq_rise && !consume_i) |=> go_o);

  a_r9_no_edge_no_go: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !edge_pend && !drq_rise) |=> (!go_o || !$stable(mode_i)));

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BLK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              drq_i,
  input  logic              cfg_dev_to_mem_i,
  input  logic [1:0]        cfg_size_i,
  input  logic [1:0]        cfg_dev_step_i,
  input  logic [1:0]        cfg_mem_step_i,
  input  logic [1:0]        cfg_chain_i,
  input  logic [1:0]        cfg_pace_i,
  input  logic [1:0]        cfg_xfer_class_i,
  input  logic [31:0]       init_dev_addr_i,
  input  logic [31:0]       init_mem_addr_i,
  input  logic [CNT_W-1:0]  init_count_i,
  input  logic [31:0]       init_base_i,
  input  logic [BLK_W-1:0]  init_blocks_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [15:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              cpu_hold_o,
  output logic              done_o
);

  seq_state_e state;
  logic              beat;
  logic [1:0]        desc_idx;
  logic [WORD_W-1:0] buf_hi, buf_lo;
  logic [CNT_W-1:0]  cnt;
  logic [BLK_W-1:0]  blocks;
  logic [ADDR_W-1:0] base;

  logic       c_dir, c_chain, c_burst;
  logic [1:0] c_size, c_devc, c_memc, c_pace;

  // named internal events
  logic              beat_done, last_beat, op_end, start_ok, go, consume;
  logic              desc_hi_ld, desc_lo_ld, mem_ld, chain_more;
  logic [CNT_W-1:0]  cnt_next;
  logic [ADDR_W-1:0] dev_addr, mem_addr, src_addr, dst_addr, mem_ld_val;

  assign beat_done  = mem_req_o & mem_ack_i & ~abort_i;
  assign last_beat  = ~f_is_long(c_size) | beat;
  assign op_end     = (state == S_WR) & beat_done & last_beat;
  assign start_ok   = (state == S_IDLE) & start_i & ~abort_i;
  assign consume    = (state == S_WAIT) & go & ~abort_i;
  assign cnt_next   = (cnt == '0) ? '0 : cnt - 1'b1;
  assign chain_more = c_chain & (blocks != '0);
  assign desc_hi_ld = (state == S_DESC) & beat_done & (desc_idx == 2'd0);
  assign desc_lo_ld = (state == S_DESC) & beat_done & (desc_idx == 2'd1);
  assign mem_ld     = start_ok | desc_hi_ld | desc_lo_ld;
  assign busy_o     = (state != S_IDLE);

  always_comb begin
    if (start_ok)        mem_ld_val = init_mem_addr_i;
    else if (desc_hi_ld) mem_ld_val = {mem_rdata_i, mem_addr[15:0]};
    else                 mem_ld_val = {mem_addr[31:16], mem_rdata_i};
  end

  dma_seq_addr_reg u_dev_addr (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .load_val_i(init_dev_addr_i),
    .step_i(op_end), .ctrl_i(c_devc), .size_i(c_size), .addr_o(dev_addr)
  );

  dma_seq_addr_reg u_mem_addr (
    .clk(clk), .rst_n(rst_n), .load_i(mem_ld), .load_val_i(mem_ld_val),
    .step_i(op_end), .ctrl_i(c_memc), .size_i(c_size), .addr_o(mem_addr)
  );

  dma_seq_pace u_pace (
    .clk(clk), .rst_n(rst_n), .active_i(busy_o), .mode_i(c_pace),
    .drq_i(drq_i), .consume_i(consume), .go_o(go)
  );

  assign src_addr = c_dir ? dev_addr : mem_addr;
  assign dst_addr = c_dir ? mem_addr : dev_addr;

  always_comb begin
    mem_req_o   = (state == S_DESC) || (state == S_RD) || (state == S_WR);
    mem_we_o    = (state == S_WR);
    mem_addr_o  = '0;
    mem_be_o    = 2'b00;
    mem_wdata_o = '0;
    case (state)
      S_DESC: begin
        mem_addr_o = base + ADDR_W'({desc_idx, 1'b0});
        mem_be_o   = 2'b11;
      end
      S_RD: begin
        mem_addr_o = src_addr + ADDR_W'({beat, 1'b0});
        mem_be_o   = f_byte_en(c_size, src_addr[0]);
      end
      S_WR: begin
        mem_addr_o  = dst_addr + ADDR_W'({beat, 1'b0});
        mem_be_o    = f_byte_en(c_size, dst_addr[0]);
        mem_wdata_o = f_is_byte(c_size) ? {buf_hi[7:0], buf_hi[7:0]}
                                        : (beat ? buf_lo : buf_hi);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; beat <= 1'b0; desc_idx <= '0;
      buf_hi <= '0; buf_lo <= '0; cnt <= '0; blocks <= '0; base <= '0;
      c_dir <= 1'b0; c_chain <= 1'b0; c_burst <= 1'b0;
      c_size <= '0; c_devc <= '0; c_memc <= '0; c_pace <= '0;
      cpu_hold_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        state      <= S_IDLE;
        beat       <= 1'b0;
        cpu_hold_o <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (start_i) begin
            c_dir   <= cfg_dev_to_mem_i;
            c_size  <= cfg_size_i;
            c_devc  <= cfg_dev_step_i;
            c_memc  <= cfg_mem_step_i;
            c_pace  <= cfg_pace_i;
            c_chain <= |cfg_chain_i;
            c_burst <= (cfg_xfer_class_i == 2'b00);
            cpu_hold_o <= (cfg_xfer_class_i == 2'b00);
            cnt     <= init_count_i;
            base    <= init_base_i;
            beat    <= 1'b0;
            desc_idx <= '0;
            if (|cfg_chain_i) begin
              blocks <= (init_blocks_i != '0) ? init_blocks_i - 1'b1 : '0;
              state  <= S_DESC;
            end else begin
              blocks <= init_blocks_i;
              state  <= S_WAIT;
            end
          end
          S_DESC: if (beat_done) begin
            if (desc_idx == 2'd2) begin
              cnt      <= CNT_W'(mem_rdata_i);
              desc_idx <= '0;
              state    <= S_WAIT;
            end else begin
              desc_idx <= desc_idx + 2'd1;
            end
          end
          S_WAIT: if (go) begin
            beat  <= 1'b0;
            state <= S_RD;
          end
          S_RD: if (beat_done) begin
            if (f_is_byte(c_size))
              buf_hi <= {8'h00, src_addr[0] ? mem_rdata_i[7:0] : mem_rdata_i[15:8]};
            else if (beat)
              buf_lo <= mem_rdata_i;
            else
              buf_hi <= mem_rdata_i;
            if (last_beat) begin
              beat  <= 1'b0;
              state <= S_WR;
            end else begin
              beat <= 1'b1;
            end
          end
          S_WR: if (beat_done) begin
            if (!last_beat) begin
              beat <= 1'b1;
            end else begin
              beat <= 1'b0;
              cnt  <= cnt_next;
              if (cnt_next != '0) begin
                state <= S_WAIT;
              end else if (chain_more) begin
                blocks   <= blocks - 1'b1;
                base     <= base + ADDR_W'(DESC_BYTES);
                desc_idx <= '0;
                state    <= S_DESC;
              end else begin
                state      <= S_IDLE;
                done_o     <= 1'b1;
                cpu_hold_o <= 1'b0;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !cpu_hold_o));

  a_r8_hold_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold_o |-> (busy_o && c_burst));

  a_r13_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r13_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_end && cnt_next == '0 && !chain_more |=> (done_o && !busy_o));

  a_r11_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !mem_req_o && !cpu_hold_o && !done_o));

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !abort_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_be_o)));

  a_r3_lanes_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_be_o != 2'b00));

  a_r6_desc_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DESC && mem_req_o) |-> !mem_we_o);

endmodule

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;

  localparam int MB = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0, drq_i = 1'b0;
  logic        cfg_dev_to_mem_i = 1'b0;
  logic [1:0]  cfg_size_i = '0, cfg_dev_step_i = '0, cfg_mem_step_i = '0;
  logic [1:0]  cfg_chain_i = '0, cfg_pace_i = '0, cfg_xfer_class_i = 2'b01;
  logic [31:0] init_dev_addr_i = '0, init_mem_addr_i = '0, init_base_i = '0;
  logic [15:0] init_count_i = '0;
  logic [7:0]  init_blocks_i = '0;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [1:0]  mem_be_o;
  logic [15:0] mem_wdata_o, mem_rdata_i = '0;
  logic        busy_o, cpu_hold_o, done_o;

  dma_chain_seq u_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .drq_i(drq_i),
    .cfg_dev_to_mem_i(cfg_dev_to_mem_i), .cfg_size_i(cfg_size_i),
    .cfg_dev_step_i(cfg_dev_step_i), .cfg_mem_step_i(cfg_mem_step_i),
    .cfg_chain_i(cfg_chain_i), .cfg_pace_i(cfg_pace_i), .cfg_xfer_class_i(cfg_xfer_class_i),
    .init_dev_addr_i(init_dev_addr_i), .init_mem_addr_i(init_mem_addr_i),
    .init_count_i(init_count_i), .init_base_i(init_base_i), .init_blocks_i(init_blocks_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .cpu_hold_o(cpu_hold_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  logic [7:0] mb [MB];
  logic [7:0] rb [MB];
  int checks = 0, fails = 0, cyc = 0;
  int wr_beats = 0, done_cnt = 0, hold_bad = 0, hs_bad = 0, rd_n = 0;
  logic [31:0] rd_log [16];
  logic exp_hold = 1'b0;
  logic prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [1:0]  prev_be = '0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory model, observation and watchdog, all away from the active edge
  always @(negedge clk) begin
    int a;
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      summary();
    end
    if (rst_n) begin
      if (prev_wait && mem_req_o && (mem_addr_o != prev_addr || mem_be_o != prev_be)) hs_bad++;
      if (busy_o && cpu_hold_o != exp_hold) hold_bad++;
      if (!busy_o && cpu_hold_o) hold_bad++;
      if (done_o) done_cnt++;
    end
    a = int'(mem_addr_o[10:0]) & ~1;
    if (mem_req_o && (cyc % 3 != 0)) begin
      mem_ack_i = 1'b1;
      if (mem_we_o) begin
        if (mem_be_o[1]) mb[a]   = mem_wdata_o[15:8];
        if (mem_be_o[0]) mb[a+1] = mem_wdata_o[7:0];
        wr_beats++;
        mem_rdata_i = '0;
      end else begin
        mem_rdata_i = {mb[a], mb[a+1]};
        if (rd_n < 16) rd_log[rd_n] = mem_addr_o;
        rd_n++;
      end
      prev_wait = 1'b0;
    end else begin
      mem_ack_i   = 1'b0;
      mem_rdata_i = '0;
      prev_wait   = mem_req_o;
    end
    prev_addr = mem_addr_o;
    prev_be   = mem_be_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < MB; i++) begin
      mb[i] = 8'(i * 37 + (i >> 4) * 11 + 5);
      rb[i] = mb[i];
    end
  endtask

  task automatic put_word(input int a, input logic [15:0] w);
    mb[a] = w[15:8]; mb[a+1] = w[7:0];
    rb[a] = w[15:8]; rb[a+1] = w[7:0];
  endtask

  // byte-level restatement: n operands, each copied through a snapshot
  task automatic ref_block(input bit dir, input logic [1:0] sz, input logic [1:0] dc,
                           input logic [1:0] mc, inout int dev, inout int mem, input int n);
    int nb;
    logic [7:0] tmp [4];
    nb = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
    for (int k = 0; k < n; k++) begin
      int s, d;
      s = dir ? dev : mem;
      d = dir ? mem : dev;
      for (int j = 0; j < nb; j++) tmp[j] = rb[(s + j) & (MB-1)];
      for (int j = 0; j < nb; j++) rb[(d + j) & (MB-1)] = tmp[j];
      if (dc == 2'b01) dev += nb; else if (dc == 2'b10) dev -= nb;
      if (mc == 2'b01) mem += nb; else if (mc == 2'b10) mem -= nb;
    end
  endtask

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < MB; i++) if (mb[i] !== rb[i]) d++;
    return d;
  endfunction

  task automatic clear_stats();
    wr_beats = 0; done_cnt = 0; hold_bad = 0; hs_bad = 0; rd_n = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int n = 0;
    while (done_cnt == d0 && n < 4000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    init_mem();
    idle(3);
    chk(!busy_o && !mem_req_o && !cpu_hold_o && !done_o, "R1", "reset outputs",
        {busy_o, mem_req_o, cpu_hold_o, done_o}, 0);
    rst_n = 1'b1;
    idle(2);
    chk(!busy_o && !mem_req_o, "R1", "idle after reset", {busy_o, mem_req_o}, 0);

    // sweep direction, size and both step codes
    for (int dir = 0; dir < 2; dir++)
      for (int sz = 0; sz < 4; sz++)
        for (int dc = 0; dc < 4; dc++)
          for (int mc = 0; mc < 4; mc++) begin
            int dev, mem, exp_wr;
            bit byte_op;
            byte_op = (sz == 0 || sz == 3);
            init_mem(); clear_stats();
            dev = byte_op ? 'h201 : 'h200;
            mem = (byte_op && dir == 1) ? 'h501 : 'h500;
            cfg_dev_to_mem_i = dir[0]; cfg_size_i = 2'(sz);
            cfg_dev_step_i = 2'(dc); cfg_mem_step_i = 2'(mc);
            cfg_chain_i = 2'b00; cfg_pace_i = 2'b00;
            cfg_xfer_class_i = (dc == mc) ? 2'b00 : 2'b01;
            exp_hold = (dc == mc);
            init_dev_addr_i = 32'(dev); init_mem_addr_i = 32'(mem); init_count_i = 16'd3;
            ref_block(dir[0], 2'(sz), 2'(dc), 2'(mc), dev, mem, 3);
            pulse_start();
            wait_done(0);
            exp_wr = (sz == 2) ? 6 : 3;
            chk(mem_diffs() == 0, "R2 R3 R4", "memory image mismatching bytes", mem_diffs(), 0);
            chk(wr_beats == exp_wr, "R5", "write beats", wr_beats, exp_wr);
            chk(hold_bad == 0, "R8", "hold violations", hold_bad, 0);
            chk(hs_bad == 0, "R12", "request changed before ack", hs_bad, 0);
            chk(done_cnt == 1 && !busy_o, "R13", "done pulses", done_cnt, 1);
          end

    // R5: zero count moves one operand
    begin
      int dev = 'h300, mem = 'h600;
      init_mem(); clear_stats(); exp_hold = 1'b0;
      cfg_dev_to_mem_i = 1'b1; cfg_size_i = 2'b01; cfg_dev_step_i = 2'b01; cfg_mem_step_i = 2'b01;
      cfg_xfer_class_i = 2'b01; init_dev_addr_i = 32'(dev); init_mem_addr_i = 32'(mem);
      init_count_i = 16'd0;
      ref_block(1'b1, 2'b01, 2'b01, 2'b01, dev, mem, 1);
      pulse_start(); wait_done(0);
      chk(wr_beats == 1, "R5", "zero-count operands", wr_beats, 1);
      chk(mem_diffs() == 0, "R5", "zero-count image", mem_diffs(), 0);
    end

    // R6/R7: chained run over two descriptors
    begin
      int dev = 'h200, mem;
      init_mem(); clear_stats(); exp_hold = 1'b0;
      put_word('h700, 16'h0000); put_word('h702, 16'h0580); put_word('h704, 16'd2);
      put_word('h706, 16'h0000); put_word('h708, 16'h05C0); put_word('h70A, 16'd1);
      put_word('h70C, 16'h0000); put_word('h70E, 16'h0600); put_word('h710, 16'd3);
      cfg_chain_i = 2'b01; cfg_size_i = 2'b01; cfg_dev_to_mem_i = 1'b1;
      cfg_dev_step_i = 2'b01; cfg_mem_step_i = 2'b01; cfg_xfer_class_i = 2'b01;
      init_dev_addr_i = 32'(dev); init_mem_addr_i = 32'h123; init_count_i = 16'd9;
      init_base_i = 32'h700; init_blocks_i = 8'd2;
      mem = 'h580; ref_block(1'b1, 2'b01, 2'b01, 2'b01, dev, mem, 2);
      mem = 'h5C0; ref_block(1'b1, 2'b01, 2'b01, 2'b01, dev, mem, 1);
      pulse_start(); wait_done(0);
      chk(rd_log[0] == 32'h700 && rd_log[1] == 32'h702 && rd_log[2] == 32'h704,
          "R6", "descriptor read order (first)", rd_log[1], 32'h702);
      chk(rd_log[5] == 32'h706, "R7", "second descriptor address", rd_log[5], 32'h706);
      chk(wr_beats == 3, "R7", "chained write beats", wr_beats, 3);
      chk(mem_diffs() == 0, "R7", "chained image", mem_diffs(), 0);
      chk(done_cnt == 1, "R7", "chained done pulses", done_cnt, 1);

      for (int b = 0; b < 2; b++) begin
        clear_stats();
        init_blocks_i = 8'(b);
        pulse_start(); wait_done(0);
        chk(wr_beats == 2, "R6", "single-descriptor write beats", wr_beats, 2);
      end
      cfg_chain_i = 2'b00; init_blocks_i = 8'd0;
    end

    // R9: edge pacing
    begin
      int dev = 'h200, mem = 'h500;
      init_mem(); clear_stats(); exp_hold = 1'b0;
      cfg_pace_i = 2'b11; cfg_size_i = 2'b01; cfg_dev_to_mem_i = 1'b1;
      cfg_dev_step_i = 2'b01; cfg_mem_step_i = 2'b01; cfg_xfer_class_i = 2'b01;
      init_dev_addr_i = 32'(dev); init_mem_addr_i = 32'(mem); init_count_i = 16'd3;
      ref_block(1'b1, 2'b01, 2'b01, 2'b01, dev, mem, 3);
      pulse_start(); idle(20);
      chk(wr_beats == 0, "R9", "beats before any edge", wr_beats, 0);
      drq_i = 1'b1; idle(20);
      chk(wr_beats == 1, "R9", "beats after one edge held high", wr_beats, 1);
      drq_i = 1'b0; idle(2); drq_i = 1'b1; idle(1); drq_i = 1'b0; idle(20);
      chk(wr_beats == 2, "R9", "beats after two edges", wr_beats, 2);
      drq_i = 1'b1; idle(1); drq_i = 1'b0;
      wait_done(0);
      chk(done_cnt == 1 && mem_diffs() == 0, "R9", "edge-paced image", mem_diffs(), 0);
    end

    // R10: level pacing
    begin
      int dev = 'h200, mem = 'h500, n = 0;
      init_mem(); clear_stats(); exp_hold = 1'b0;
      cfg_pace_i = 2'b10; init_count_i = 16'd4;
      init_dev_addr_i = 32'(dev); init_mem_addr_i = 32'(mem);
      ref_block(1'b1, 2'b01, 2'b01, 2'b01, dev, mem, 4);
      pulse_start(); idle(20);
      chk(wr_beats == 0, "R10", "beats while DRQ low", wr_beats, 0);
      drq_i = 1'b1;
      while (wr_beats < 1 && n < 200) begin @(negedge clk); n++; end
      drq_i = 1'b0; idle(20);
      chk(wr_beats == 1, "R10", "beats after DRQ dropped", wr_beats, 1);
      drq_i = 1'b1;
      wait_done(0);
      drq_i = 1'b0;
      chk(wr_beats == 4 && mem_diffs() == 0, "R10", "level-paced beats", wr_beats, 4);
      cfg_pace_i = 2'b00;
    end

    // R13: start while busy is ignored
    begin
      clear_stats(); exp_hold = 1'b0;
      init_count_i = 16'd4; cfg_size_i = 2'b01;
      pulse_start(); idle(3);
      init_count_i = 16'd1; pulse_start();
      wait_done(0);
      chk(wr_beats == 4, "R13", "beats with start while busy", wr_beats, 4);
      chk(done_cnt == 1, "R13", "done pulses with start while busy", done_cnt, 1);
    end

    // R11: abort mid-run, then restart
    begin
      int n = 0, w;
      clear_stats(); exp_hold = 1'b1;
      cfg_xfer_class_i = 2'b00; init_count_i = 16'd6;
      pulse_start();
      while (wr_beats < 2 && n < 200) begin @(negedge clk); n++; end
      abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
      chk(!busy_o && !mem_req_o && !cpu_hold_o, "R11", "state after abort",
          {busy_o, mem_req_o, cpu_hold_o}, 0);
      w = wr_beats; idle(20);
      chk(done_cnt == 0 && wr_beats == w, "R11", "done pulses after abort", done_cnt, 0);
      clear_stats(); init_count_i = 16'd2;
      pulse_start(); wait_done(0);
      chk(wr_beats == 2 && done_cnt == 1, "R11", "restart after abort beats", wr_beats, 2);
      chk(hold_bad == 0, "R8", "hold after restart", hold_bad, 0);
    end

    summary();
  end

endmodule